// File: doc/BRIEF.md
# IO DMA Address Translator

This block sits between an IO bus requester and system memory. It turns DMA virtual addresses into physical addresses. Each request carries a virtual address, a write flag and the requester's bus ID. The block does one of three things with it. It passes a bypass-form address straight through. It looks up a translation entry in an in-memory table. Or it reports a translation fault. The bus ID picks one of several translation tables through a device map. Each table has a descriptor that holds its base address, its page size and its table size. Only one request is in flight at a time. A table walk issues exactly one 64-bit read on a simple memory read port.

Configuration lives in a small word-addressed CSR space. It holds a control word, sixteen map words, eight table descriptors and the fault record. The first fault after the interrupt is cleared captures the faulting virtual address, a cause code and the bus ID, and raises `irq`. Writing a one to bit 0 of the clear register drops the interrupt.

Both data streams use valid/ready handshakes:
- **Request:** a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been taken.
- **Response:** once `rsp_valid` rises, it stays high with `rsp_pa` and `rsp_fault` unchanged until `rsp_ready` is seen.
- **Memory read:** `mem_req_valid` and `mem_addr` are held until `mem_req_ready`. The read data returns later as a single-cycle `mem_rsp_valid` pulse, which the block always accepts.

Top module: `iotr_xlate`

CSR word addresses (`csr_addr`):

| Address | Register | Access |
|---|---|---|
| 0x00 | control | read/write |
| 0x10 to 0x1F | map words 0 to 15 | read/write |
| 0x20 to 0x27 | descriptors 0 to 7 | read/write |
| 0x30 | interrupt status | read |
| 0x31 | interrupt clear | write |
| 0x32 | fault virtual address | read |
| 0x33 | fault status | read |

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, `irq`=0, and the control word reads 0.
- R2: An address is bypass-form when VA[63:50] are all ones and VA[49:40] are all zero. A bypass-form request with control bit 1 set completes with PA = VA[39:0] zero-extended. It has no fault and issues no memory read, whether or not translation is enabled.
- R3: An address with any of VA[49:40] set is never bypassed. The same holds for a bypass-form address while control bit 1 is clear. Such a request takes the translation path.
- R4: A request on the translation path while control bit 0 is clear faults with cause 1 and issues no memory read.
- R5: Map index selection:
  - When control bit 3 is set, the map index is busid[5:0]; otherwise it is busid[6:0].
  - Map word index/8 holds eight 8-bit table numbers, with the lowest index in bits 63:56.
  - When control bit 2 is clear, table number 0 is used for every bus ID.
- R6: A table number of 8 or more, or a descriptor whose bit 63 is clear, gives a fault with cause 2 and no memory read.
- R7: The page-size code in descriptor bits 6:4 selects the page-offset width:
  - code 0 gives 13 bits, code 1 gives 16 bits, code 3 gives 22 bits and code 5 gives 28 bits;
  - any other code faults with cause 3 and issues no memory read.
- R8: The entry read address is {desc[39:13], 13'b0} + 8 × ((VA >> offset width) & ((1024 << desc[3:0]) − 1)).
- R9: A good entry gives PA = ({entry[38:13], 13'b0} with the offset bits cleared) OR (VA offset bits). PA bits 63:39 are zero.
- R10: An entry with bit 0 clear faults with cause 4. A write to an entry with bit 1 clear faults with cause 5. A read of that same entry succeeds.
- R11: Fault capture and interrupt:
  - A fault sets `irq` and, if `irq` was clear, captures the VA at 0x32 and the status {bus ID at bits 15:8, cause at bits 3:0} at 0x33.
  - Later faults leave the record unchanged until the interrupt is cleared.
  - Writing 1 to bit 0 of 0x31 clears `irq`; writing 0 has no effect.
- R12: A response is held stable under back-pressure, and `req_ready` stays low while a request is in flight.
- R13: The control word keeps only bits 9:8 and 3:0. Bits 9:8 read back as written and have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 6 | CSR word address |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data (combinational from `csr_addr`) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_va | input | 64 | Request virtual address |
| req_write | input | 1 | Request is a write |
| req_busid | input | 8 | Requester bus ID |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_pa | output | 64 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Response is a translation fault |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Entry read request ready |
| mem_addr | output | 64 | Entry read byte address |
| mem_rsp_valid | input | 1 | Entry read data valid (single-cycle pulse) |
| mem_rsp_data | input | 64 | Entry read data |
| irq | output | 1 | Translation fault interrupt |

## Verification
The assertions assume three things about the inputs:
- the memory side returns exactly one `mem_rsp_valid` pulse for each accepted read, and never one unprompted;
- CSR writes to the map, descriptors and control word are not made while a request is in flight;
- the requester holds its request fields stable while `req_valid` waits for `req_ready`.

The stimulus keeps within these assumptions. A single responder answers each accepted read after a fixed delay, all configuration writes happen between requests, and the driver changes request fields only after a handshake. Ready on the response and memory-request sides is toggled from a pseudo-random sequence to exercise the hold rules.

// File: rtl/iotr_pkg.sv
package iotr_pkg;

  typedef enum logic [3:0] {
    CAUSE_NONE   = 4'd0,
    CAUSE_OFF    = 4'd1,
    CAUSE_DESC   = 4'd2,
    CAUSE_PGSZ   = 4'd3,
    CAUSE_INVAL  = 4'd4,
    CAUSE_WPROT  = 4'd5
  } cause_e;

  typedef enum logic [2:0] {
    W_IDLE, W_DECIDE, W_FETCH, W_WAIT, W_RESP
  } walk_st_e;

  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_MAP  = 6'h10;
  localparam logic [5:0] A_DESC = 6'h20;
  localparam logic [5:0] A_IRQ  = 6'h30;
  localparam logic [5:0] A_CLR  = 6'h31;
  localparam logic [5:0] A_FVA  = 6'h32;
  localparam logic [5:0] A_FST  = 6'h33;

  // Page-offset width for a page-size code; 0 marks an illegal code.
  function automatic logic [5:0] page_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd13;
      3'd1:    return 6'd16;
      3'd3:    return 6'd22;
      3'd5:    return 6'd28;
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/iotr_csr.sv
module iotr_csr
  import iotr_pkg::*;
#(
  parameter int MAP_WORDS = 16,
  parameter int NUM_DESC  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [5:0]  csr_addr,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  input  logic [7:0]  lk_busid,
  output logic [63:0] lk_desc,
  output logic        lk_tnum_ok,
  output logic        xlate_en,
  output logic        bypass_en,
  input  logic        fault_evt,
  input  logic [63:0] fault_va,
  input  cause_e      fault_cause,
  input  logic [7:0]  fault_busid,
  output logic        irq
);
  localparam int IDX_W  = $clog2(MAP_WORDS * 8);
  localparam int TSEL_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;

  logic [9:0]  ctrl_q;
  logic [63:0] map_q  [MAP_WORDS];
  logic [63:0] desc_q [NUM_DESC];
  logic        irq_q;
  logic [63:0] fva_q;
  logic [15:0] fst_q;
  logic        clr_hit;

  assign clr_hit = csr_we && (csr_addr == A_CLR) && csr_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (csr_we && csr_addr == A_CTRL)
      ctrl_q <= {csr_wdata[9:8], 4'b0000, csr_wdata[3:0]};
  end

  for (genvar g = 0; g < MAP_WORDS; g++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rst_n) map_q[g] <= '0;
      else if (csr_we && csr_addr == A_MAP + 6'(g)) map_q[g] <= csr_wdata;
    end
  end

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rst_n) desc_q[g] <= '0;
      else if (csr_we && csr_addr == A_DESC + 6'(g)) desc_q[g] <= csr_wdata;
    end
  end

  // Fault record: first fault after a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fva_q <= '0;
      fst_q <= '0;
    end else begin
      if (fault_evt && !irq_q) begin
        fva_q <= fault_va;
        fst_q <= {fault_busid, 4'b0000, fault_cause};
      end
      if (fault_evt)    irq_q <= 1'b1;
      else if (clr_hit) irq_q <= 1'b0;
    end
  end

  assign irq       = irq_q;
  assign xlate_en  = ctrl_q[0];
  assign bypass_en = ctrl_q[1];

  // Device map and descriptor lookup
  logic [IDX_W-1:0] idx;
  logic [63:0]      mword;
  logic [7:0]       tnum;
  always_comb begin
    idx        = ctrl_q[3] ? IDX_W'(lk_busid[5:0]) : lk_busid[IDX_W-1:0];
    mword      = map_q[idx[IDX_W-1:3]];
    tnum       = ctrl_q[2] ? mword[8*(7-idx[2:0]) +: 8] : 8'd0;
    lk_tnum_ok = int'(tnum) < NUM_DESC;
    lk_desc    = lk_tnum_ok ? desc_q[tnum[TSEL_W-1:0]] : '0;
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_CTRL: csr_rdata = {54'd0, ctrl_q};
      A_IRQ:  csr_rdata = {63'd0, irq_q};
      A_FVA:  csr_rdata = fva_q;
      A_FST:  csr_rdata = {48'd0, fst_q};
      default: begin
        for (int i = 0; i < MAP_WORDS; i++)
          if (csr_addr == A_MAP + 6'(i)) csr_rdata = map_q[i];
        for (int i = 0; i < NUM_DESC; i++)
          if (csr_addr == A_DESC + 6'(i)) csr_rdata = desc_q[i];
      end
    endcase
  end

  a_r11_fault_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> irq_q);
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_hit) |=> irq_q);
  a_r11_record_kept: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> ($stable(fva_q) && $stable(fst_q)));
  a_r13_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:4] == 4'b0000);

endmodule

// File: rtl/iotr_walk.sv
module iotr_walk
  import iotr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_va,
  input  logic        req_write,
  input  logic [7:0]  req_busid,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_pa,
  output logic        rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic [7:0]  lk_busid,
  input  logic [63:0] lk_desc,
  input  logic        lk_tnum_ok,
  input  logic        xlate_en,
  input  logic        bypass_en,
  output logic        fault_evt,
  output logic [63:0] fault_va,
  output cause_e      fault_cause,
  output logic [7:0]  fault_busid
);
  walk_st_e    st_q;
  logic [63:0] va_q, pa_q, maddr_q;
  logic        wr_q, flt_q;
  logic [7:0]  bus_q;
  logic [5:0]  sh_q;

  // Decide-stage evaluation (registered request, CSR lookup)
  logic        byp;
  logic [5:0]  sh;
  logic [63:0] tmask, tidx, faddr;
  cause_e      dec_cause;
  always_comb begin
    byp   = bypass_en && (&va_q[63:50]) && (va_q[49:40] == 10'd0);
    sh    = page_shift(lk_desc[6:4]);
    tmask = (64'd1024 << lk_desc[3:0]) - 64'd1;
    tidx  = (va_q >> sh) & tmask;
    faddr = {24'd0, lk_desc[39:13], 13'd0} + (tidx << 3);
    if (byp)                            dec_cause = CAUSE_NONE;
    else if (!xlate_en)                 dec_cause = CAUSE_OFF;
    else if (!lk_tnum_ok || !lk_desc[63]) dec_cause = CAUSE_DESC;
    else if (sh == 6'd0)                dec_cause = CAUSE_PGSZ;
    else                                dec_cause = CAUSE_NONE;
  end

  // Entry evaluation
  logic [63:0] omask, ent_pa;
  cause_e      ent_cause;
  always_comb begin
    omask  = (64'd1 << sh_q) - 64'd1;
    ent_pa = ({25'd0, mem_rsp_data[38:13], 13'd0} & ~omask) | (va_q & omask);
    if (!mem_rsp_data[0])              ent_cause = CAUSE_INVAL;
    else if (wr_q && !mem_rsp_data[1]) ent_cause = CAUSE_WPROT;
    else                               ent_cause = CAUSE_NONE;
  end

  always_comb begin
    fault_evt   = 1'b0;
    fault_cause = CAUSE_NONE;
    if (st_q == W_DECIDE && dec_cause != CAUSE_NONE) begin
      fault_evt   = 1'b1;
      fault_cause = dec_cause;
    end else if (st_q == W_WAIT && mem_rsp_valid && ent_cause != CAUSE_NONE) begin
      fault_evt   = 1'b1;
      fault_cause = ent_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      bus_q   <= '0;
      sh_q    <= '0;
      pa_q    <= '0;
      flt_q   <= 1'b0;
      maddr_q <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          bus_q <= req_busid;
          st_q  <= W_DECIDE;
        end
        W_DECIDE: begin
          if (byp) begin
            pa_q  <= {24'd0, va_q[39:0]};
            flt_q <= 1'b0;
            st_q  <= W_RESP;
          end else if (dec_cause != CAUSE_NONE) begin
            pa_q  <= '0;
            flt_q <= 1'b1;
            st_q  <= W_RESP;
          end else begin
            sh_q    <= sh;
            maddr_q <= faddr;
            st_q    <= W_FETCH;
          end
        end
        W_FETCH: if (mem_req_ready) st_q <= W_WAIT;
        W_WAIT: if (mem_rsp_valid) begin
          flt_q <= (ent_cause != CAUSE_NONE);
          pa_q  <= (ent_cause != CAUSE_NONE) ? 64'd0 : ent_pa;
          st_q  <= W_RESP;
        end
        W_RESP: if (rsp_ready) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == W_IDLE);
  assign rsp_valid     = (st_q == W_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = flt_q;
  assign mem_req_valid = (st_q == W_FETCH);
  assign mem_addr      = maddr_q;
  assign lk_busid      = bus_q;
  assign fault_va      = va_q;
  assign fault_busid   = bus_q;

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));
  a_r12_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  a_r9_pa_width: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_pa[63:40] == 24'd0));
  a_r11_fault_resp: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (rsp_valid && rsp_fault));

endmodule

// File: rtl/iotr_xlate.sv
module iotr_xlate
  import iotr_pkg::*;
#(
  parameter int MAP_WORDS = 16,
  parameter int NUM_DESC  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [5:0]  csr_addr,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_va,
  input  logic        req_write,
  input  logic [7:0]  req_busid,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_pa,
  output logic        rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        irq
);
  logic [7:0]  lk_busid;
  logic [63:0] lk_desc;
  logic        lk_tnum_ok, xlate_en, bypass_en;
  logic        fault_evt;
  logic [63:0] fault_va;
  cause_e      fault_cause;
  logic [7:0]  fault_busid;

  iotr_csr #(.MAP_WORDS(MAP_WORDS), .NUM_DESC(NUM_DESC)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .lk_busid(lk_busid), .lk_desc(lk_desc), .lk_tnum_ok(lk_tnum_ok),
    .xlate_en(xlate_en), .bypass_en(bypass_en),
    .fault_evt(fault_evt), .fault_va(fault_va), .fault_cause(fault_cause),
    .fault_busid(fault_busid), .irq(irq)
  );

  iotr_walk u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_busid(req_busid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lk_busid(lk_busid), .lk_desc(lk_desc), .lk_tnum_ok(lk_tnum_ok),
    .xlate_en(xlate_en), .bypass_en(bypass_en),
    .fault_evt(fault_evt), .fault_va(fault_va), .fault_cause(fault_cause),
    .fault_busid(fault_busid)
  );

endmodule

// File: tb/iotr_xlate_tb.sv
module iotr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_busid = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_pa;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        irq;

  always #5 clk = ~clk;

  iotr_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_busid(req_busid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    logic        fault;
    logic [63:0] pa;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [63:0] tmem [logic [63:0]];
  logic [63:0] b_ctrl = '0;
  logic [63:0] b_map [16];
  logic [63:0] b_desc [8];
  int          mem_reads = 0;
  logic [63:0] last_maddr = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [5:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 1'b0;
    if (a == 6'h00) b_ctrl = d & 64'h30F;
    else if (a >= 6'h10 && a < 6'h20) b_map[a - 6'h10] = d;
    else if (a >= 6'h20 && a < 6'h28) b_desc[a - 6'h20] = d;
  endtask

  task automatic rd_csr(input logic [5:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  // Reference model written from the requirements.
  function automatic void model(input logic [63:0] va, input logic wr, input logic [7:0] bus,
                                output logic f, output logic [63:0] pa, output logic [3:0] cause,
                                output logic [63:0] ea, output int rd);
    int          idx;
    logic [7:0]  tn;
    logic [63:0] d, e, m;
    int          sh;
    f = 1'b0; pa = '0; cause = '0; ea = '0; rd = 0; sh = 0;
    if (b_ctrl[1] && (&va[63:50]) && va[49:40] == 10'd0) begin
      pa = {24'd0, va[39:0]};
      return;
    end
    if (!b_ctrl[0]) begin f = 1'b1; cause = 4'd1; return; end
    idx = b_ctrl[3] ? int'(bus[5:0]) : int'(bus[6:0]);
    tn  = b_ctrl[2] ? 8'(b_map[idx / 8] >> (8 * (7 - (idx % 8)))) : 8'd0;
    if (tn >= 8 || !b_desc[tn[2:0]][63]) begin f = 1'b1; cause = 4'd2; return; end
    d = b_desc[tn[2:0]];
    case (d[6:4])
      3'd0: sh = 13;
      3'd1: sh = 16;
      3'd3: sh = 22;
      3'd5: sh = 28;
      default: begin f = 1'b1; cause = 4'd3; return; end
    endcase
    ea = {24'd0, d[39:13], 13'd0} + (((va >> sh) & ((64'd1024 << d[3:0]) - 64'd1)) << 3);
    rd = 1;
    e  = tmem.exists(ea) ? tmem[ea] : 64'd0;
    if (!e[0]) begin f = 1'b1; cause = 4'd4; return; end
    if (wr && !e[1]) begin f = 1'b1; cause = 4'd5; return; end
    m  = (64'd1 << sh) - 64'd1;
    pa = ({25'd0, e[38:13], 13'd0} & ~m) | (va & m);
  endfunction

  task automatic put_ent(input logic [63:0] va, input logic [7:0] bus, input logic [63:0] ent);
    logic f; logic [63:0] pa, ea; logic [3:0] c; int rd;
    model(va, 1'b0, bus, f, pa, c, ea, rd);
    if (rd == 1) tmem[ea] = ent;
  endtask

  task automatic do_req(input logic [63:0] va, input logic wr, input logic [7:0] bus,
                        input string tag, input bit keep_irq);
    logic f; logic [63:0] pa, ea, v; logic [3:0] c; int rd; int r0;
    exp_t x;
    model(va, wr, bus, f, pa, c, ea, rd);
    x.fault = f; x.pa = pa; x.tag = tag;
    exp_q.push_back(x);
    r0 = mem_reads;
    @(posedge clk); #1;
    req_valid = 1'b1; req_va = va; req_write = wr; req_busid = bus;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R12", "req_ready while busy", {63'd0, req_ready}, 64'd0);
    while (exp_q.size() != 0) begin @(posedge clk); #2; end
    check(tag, "memory reads", 64'(mem_reads - r0), 64'(rd));
    if (rd == 1) check("R8", "entry address", last_maddr, ea);
    rd_csr(6'h30, v);
    if (f) begin
      check(tag, "irq after fault", v, 64'd1);
      if (!keep_irq) begin
        rd_csr(6'h32, v); check("R11", "fault va", v, va);
        rd_csr(6'h33, v); check("R11", "fault status", v, {48'd0, bus, 4'd0, c});
        wr_csr(6'h31, 64'd0);
        rd_csr(6'h30, v); check("R11", "clear with zero keeps irq", v, 64'd1);
        wr_csr(6'h31, 64'd1);
        rd_csr(6'h30, v); check("R11", "clear with one", v, 64'd0);
      end
    end else if (!keep_irq) begin
      check(tag, "irq quiet", v, 64'd0);
    end
  endtask

  // Pseudo-random back-pressure
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready     = lfsr[0] | lfsr[3];
    mem_req_ready = lfsr[5] | lfsr[7];
  end

  // Memory responder: fixed delay, one read at a time
  initial forever begin
    @(negedge clk);
    if (mem_req_valid && mem_req_ready) begin
      last_maddr = mem_addr;
      mem_reads++;
      @(posedge clk); #1;
      @(posedge clk); #1;
      mem_rsp_data  = tmem.exists(last_maddr) ? tmem[last_maddr] : 64'd0;
      mem_rsp_valid = 1'b1;
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
    end
  end

  // Monitor / scoreboard
  logic        hold_pend = 1'b0;
  logic [63:0] hold_pa;
  logic        hold_f;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (hold_pend) begin
        check("R12", "held valid", {63'd0, rsp_valid}, 64'd1);
        check("R12", "held pa", rsp_pa, hold_pa);
        check("R12", "held fault", {63'd0, rsp_fault}, {63'd0, hold_f});
      end
      hold_pend = rsp_valid && !rsp_ready;
      hold_pa   = rsp_pa;
      hold_f    = rsp_fault;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R12", "unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(x.tag, "fault flag", {63'd0, rsp_fault}, {63'd0, x.fault});
          check(x.tag, "physical address", rsp_pa, x.pa);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    for (int i = 0; i < 16; i++) b_map[i] = '0;
    for (int i = 0; i < 8; i++) b_desc[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "req_ready", {63'd0, req_ready}, 64'd1);
    check("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1", "mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    check("R1", "irq", {63'd0, irq}, 64'd0);
    rd_csr(6'h00, v); check("R1", "control", v, 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R13 masking of the control word
    wr_csr(6'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_csr(6'h00, v); check("R13", "control mask", v, 64'h30F);
    for (int i = 0; i < 16; i++) wr_csr(6'h10 + 6'(i), 64'h0001_0203_0405_0607);
    wr_csr(6'h11, 64'h0901_0203_0405_0607);
    wr_csr(6'h20, (64'd1 << 63) | 64'h0800_0000 | (64'd0 << 4) | 64'd0);
    wr_csr(6'h21, (64'd1 << 63) | 64'h1000_0000 | (64'd1 << 4) | 64'd1);
    wr_csr(6'h22, (64'd1 << 63) | 64'h2000_0000 | (64'd3 << 4) | 64'd2);
    wr_csr(6'h23, (64'd1 << 63) | 64'h3000_0000 | (64'd5 << 4) | 64'd0);
    wr_csr(6'h24, (64'd1 << 63) | 64'h4000_0000 | (64'd2 << 4) | 64'd0);
    wr_csr(6'h25, 64'h5000_0000 | (64'd0 << 4));

    put_ent(64'hFFFD_0000_0000_2000, 8'd0, (64'h1234 << 13) | 64'd3);
    put_ent(64'h0000_0000_0004_5678, 8'd1, (64'h55550 << 13) | 64'd1);
    put_ent(64'h0000_0000_0123_4567, 8'd2, (64'h2A0 << 13) | 64'd3);
    put_ent(64'h0000_0003_1234_5678, 8'd3, (64'h2ABCDEF << 13) | 64'd3);
    put_ent(64'h0000_0000_0000_6000, 8'h48, (64'h777 << 13) | 64'd3);

    do_req(64'hFFFC_0012_3456_7890, 1'b1, 8'd5, "R2", 1'b0);   // bypass
    do_req(64'hFFFD_0000_0000_2000, 1'b1, 8'd0, "R3", 1'b0);   // 49:40 set -> translate
    do_req(64'h0000_0000_0004_5678, 1'b0, 8'd1, "R10", 1'b0);  // read of read-only entry
    do_req(64'h0000_0000_0004_5678, 1'b1, 8'd1, "R10", 1'b0);  // write -> cause 5
    do_req(64'h0000_0000_0123_4567, 1'b1, 8'd2, "R9", 1'b0);   // 4 MB page
    do_req(64'h0000_0003_1234_5678, 1'b0, 8'd3, "R9", 1'b0);   // 256 MB page
    do_req(64'h0000_0000_0000_1000, 1'b0, 8'd4, "R7", 1'b0);   // illegal page code
    do_req(64'h0000_0000_0000_1000, 1'b0, 8'd5, "R6", 1'b0);   // invalid descriptor
    do_req(64'h0000_0000_0000_1000, 1'b0, 8'd6, "R6", 1'b0);   // unwritten descriptor
    do_req(64'h0000_0000_0000_6000, 1'b0, 8'h48, "R6", 1'b0);  // table number 9
    do_req(64'h0000_0000_0040_0000, 1'b0, 8'd0, "R10", 1'b0);  // missing entry -> cause 4

    // R5 index from busid[6:0] when bit 3 clear
    wr_csr(6'h00, 64'h307);
    do_req(64'h0000_0000_0000_6000, 1'b0, 8'h48, "R5", 1'b0);
    // R5 descriptor mode off: everything uses table 0
    wr_csr(6'h00, 64'h30B);
    do_req(64'h0000_0003_1234_5678, 1'b0, 8'd3, "R5", 1'b0);
    // R13 cache bits cleared: same translation
    wr_csr(6'h00, 64'h00F);
    rd_csr(6'h00, v); check("R13", "control readback", v, 64'h00F);
    do_req(64'h0000_0000_0123_4567, 1'b0, 8'd2, "R13", 1'b0);
    // R3 bypass disabled: bypass-form goes to translation
    wr_csr(6'h00, 64'h00D);
    do_req(64'hFFFC_0000_0000_0000, 1'b0, 8'd0, "R3", 1'b0);
    // R4 translation off faults, bypass still works
    wr_csr(6'h00, 64'h00E);
    do_req(64'h0000_0000_0123_4567, 1'b0, 8'd2, "R4", 1'b0);
    do_req(64'hFFFC_00AB_CDEF_0123, 1'b0, 8'd2, "R2", 1'b0);

    // R11 first fault kept until cleared
    do_req(64'h0000_0000_0000_A000, 1'b0, 8'd7, "R4", 1'b1);
    wr_csr(6'h00, 64'h00F);
    do_req(64'h0000_0000_0000_B000, 1'b0, 8'd4, "R7", 1'b1);
    rd_csr(6'h32, v); check("R11", "first fault va kept", v, 64'h0000_0000_0000_A000);
    rd_csr(6'h33, v); check("R11", "first fault status kept", v, {48'd0, 8'd7, 4'd0, 4'd1});
    wr_csr(6'h31, 64'd1);
    rd_csr(6'h30, v); check("R11", "irq cleared", v, 64'd0);

    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule